// File: doc/BRIEF.md
# Dual-Bank Interrupt Aggregation Controller

This block collects sixty-four interrupt request lines into two 32-bit banks and drives a single interrupt request towards a processor. Some bit positions in each bank are fixed as level-sensitive and the others as edge-sensitive. An edge-sensitive source latches a pending event on its rising edge, and that event stays latched until software acknowledges it. A level-sensitive source is pending only while its line is high. Each bank has an enable mask. The processor request is raised whenever any enabled bit of either bank is pending.

Software uses a small 32-bit register bus with a 12-bit address. Through it, software can read the latched events, read and write the enable mask, clear events by writing ones, and read the raw line levels. A parameter selects a byte-lane swap between the bus and the internal vectors, for hosts that use the opposite byte order.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, events, mask and levels of both banks are zero, `cpu_irq` is 0 and `bus_rdata` is 0.
- R2: Input line n feeds bank 1 − (n / 32) at bit n mod 32. Lines 0–31 go to bank 1 and lines 32–63 go to bank 0.
- R3: Each clock, a bank's levels vector takes the value of its input lines sampled on that clock edge.
- R4: On an edge-sensitive bit, a sampled rising edge sets the event bit. The event bit stays set after the line falls. A level-sensitive bit never sets an event. The level-sensitive selection is fixed: none in bank 0, and bits 20–28 (0x1FF00000) in bank 1.
- R5: A write to the acknowledge register clears every event bit written as one. It leaves level-sensitive pending untouched. A rising edge in the same cycle as an acknowledge of that bit leaves the bit set.
- R6: A bank is pending when (events | (levels & level_select)) & mask is non-zero. `cpu_irq` is the registered OR of both banks, one clock after the vectors change.
- R7: A bank is selected by (addr − 0x10) >> 4 taken over 12 bits. Bank 0 is at 0x10–0x1F and bank 1 is at 0x20–0x2F. Any other result reads as zero and ignores writes.
- R8: The offset is addr[3:0]. Offset 0x0 reads events, 0x4 reads and writes the mask, 0x8 is a write-only acknowledge that reads zero, and 0xC reads levels. Every other offset reads zero. Writes to any offset except 0x4 and 0x8 change nothing.
- R9: A read (`bus_valid`=1, `bus_we`=0) puts its data on `bus_rdata` at the next clock edge. `bus_rdata` holds that value until the next read.
- R10: With `SWAP_EN`=1, byte 0 and byte 3 of bus data trade places, and so do byte 1 and byte 2, in both directions. A line at bank 0 bit 0 reads back as 0x01000000. A mask written as 0x000000FF enables bits 24–31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt request lines, active high |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cpu_irq | output | 1 | Aggregated interrupt request to the processor |

## Verification
Two actions can land on the same event bit in one cycle: a rising edge on its input line and a software acknowledge of that bit. The bench raises line 33 in the same cycle as an acknowledge of bank 0 bit 1. It then reads the events register and expects the bit still set. A second acknowledge, with the line held high, must clear the bit and leave it clear, because no new edge follows. The bench also holds a level-sensitive line high while acknowledging all ones, and expects `cpu_irq` to stay asserted.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANK_W  = 32;
  localparam int BYTES_W = BANK_W / 8;

  typedef logic [BANK_W-1:0] vec_t;

  localparam vec_t LVL_SEL_B0_DEF = 32'h0000_0000;
  localparam vec_t LVL_SEL_B1_DEF = 32'h1FF0_0000;

  typedef enum logic [3:0] {
    OFS_EVENTS = 4'h0,
    OFS_MASK   = 4'h4,
    OFS_ACK    = 4'h8,
    OFS_LEVELS = 4'hC
  } reg_ofs_e;

  function automatic vec_t swap_bytes(vec_t v);
    vec_t r;
    for (int i = 0; i < BYTES_W; i++) r[i*8 +: 8] = v[(BYTES_W-1-i)*8 +: 8];
    return r;
  endfunction

  function automatic logic bank_pending(vec_t ev, vec_t lv, vec_t sel, vec_t mk);
    return |((ev | (lv & sel)) & mk);
  endfunction

  function automatic vec_t next_events(vec_t ev, vec_t rise, vec_t sel, vec_t ack);
    return (ev & ~(ack & ~sel)) | (rise & ~sel);
  endfunction
endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter vec_t LVL_SEL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  vec_t src,
  input  logic mask_we,
  input  logic ack_we,
  input  vec_t wdata,
  output vec_t events,
  output vec_t levels,
  output vec_t mask,
  output logic pending
);
  vec_t rise;
  vec_t ack_bits;

  assign rise     = src & ~levels;
  assign ack_bits = ack_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      levels <= '0;
      events <= '0;
      mask   <= '0;
    end else begin
      levels <= src;
      events <= next_events(events, rise, LVL_SEL, ack_bits);
      if (mask_we) mask <= wdata;
    end
  end

  assign pending = bank_pending(events, levels, LVL_SEL, mask);
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NBANKS  = 2,
  parameter bit SWAP_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  vec_t              bus_wdata,
  input  vec_t              ev   [NBANKS],
  input  vec_t              mk   [NBANKS],
  input  vec_t              lv   [NBANKS],
  output logic [NBANKS-1:0] mask_we,
  output logic [NBANKS-1:0] ack_we,
  output vec_t              wdata_int,
  output logic              addr_bad,
  output vec_t              bus_rdata
);
  localparam int IDX_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  logic [ADDR_W-1:0] rel_addr;
  logic [ADDR_W-1:0] idx_full;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        ofs;
  logic              wr_ok;
  logic              rd_req;
  vec_t              rd_val;
  vec_t              rd_bus;

  assign rel_addr = bus_addr - ADDR_W'(16);
  assign idx_full = rel_addr >> 4;
  assign idx      = idx_full[IDX_W-1:0];
  assign addr_bad = idx_full >= ADDR_W'(NBANKS);
  assign ofs      = bus_addr[3:0];
  assign wr_ok    = bus_valid && bus_we && !addr_bad;
  assign rd_req   = bus_valid && !bus_we;

  generate
    if (SWAP_EN) begin : g_swap
      assign wdata_int = swap_bytes(bus_wdata);
      assign rd_bus    = swap_bytes(rd_val);
    end else begin : g_direct
      assign wdata_int = bus_wdata;
      assign rd_bus    = rd_val;
    end
  endgenerate

  for (genvar b = 0; b < NBANKS; b++) begin : g_strobe
    assign mask_we[b] = wr_ok && (idx == IDX_W'(b)) && (ofs == OFS_MASK);
    assign ack_we[b]  = wr_ok && (idx == IDX_W'(b)) && (ofs == OFS_ACK);
  end

  always_comb begin
    rd_val = '0;
    if (!addr_bad) begin
      case (ofs)
        OFS_EVENTS: rd_val = ev[idx];
        OFS_MASK:   rd_val = mk[idx];
        OFS_LEVELS: rd_val = lv[idx];
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_bus;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NBANKS  = 2,
  parameter int ADDR_W  = 12,
  parameter bit SWAP_EN = 1'b0,
  parameter logic [NBANKS-1:0][BANK_W-1:0] LVL_SEL = {LVL_SEL_B1_DEF, LVL_SEL_B0_DEF}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBANKS*BANK_W-1:0] irq_in,
  input  logic                     bus_valid,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [BANK_W-1:0]        bus_wdata,
  output logic [BANK_W-1:0]        bus_rdata,
  output logic                     cpu_irq
);
  vec_t              ev_v [NBANKS];
  vec_t              mk_v [NBANKS];
  vec_t              lv_v [NBANKS];
  logic [NBANKS-1:0] pend_v;
  logic [NBANKS-1:0] mask_we;
  logic [NBANKS-1:0] ack_we;
  vec_t              wdata_int;
  logic              addr_bad;
  logic              pend_any;
  vec_t              ev_lo, ev_hi, lv_lo;

  irq_agg_regif #(
    .ADDR_W (ADDR_W),
    .NBANKS (NBANKS),
    .SWAP_EN(SWAP_EN)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ev       (ev_v),
    .mk       (mk_v),
    .lv       (lv_v),
    .mask_we  (mask_we),
    .ack_we   (ack_we),
    .wdata_int(wdata_int),
    .addr_bad (addr_bad),
    .bus_rdata(bus_rdata)
  );

  // bank b is fed by the input group counted from the top
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    irq_agg_bank #(
      .LVL_SEL(LVL_SEL[b])
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_in[(NBANKS-1-b)*BANK_W +: BANK_W]),
      .mask_we(mask_we[b]),
      .ack_we (ack_we[b]),
      .wdata  (wdata_int),
      .events (ev_v[b]),
      .levels (lv_v[b]),
      .mask   (mk_v[b]),
      .pending(pend_v[b])
    );
  end

  assign pend_any = |pend_v;
  assign ev_lo    = ev_v[0];
  assign ev_hi    = ev_v[NBANKS-1];
  assign lv_lo    = lv_v[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= pend_any;
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input vec_t hi_in,
  input vec_t lv_lo,
  input vec_t ev_lo,
  input vec_t ev_hi,
  input logic pend_any,
  input logic cpu_irq,
  input logic bus_valid,
  input logic bus_we,
  input logic addr_bad,
  input vec_t bus_rdata
);
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(pend_any))); // R6

  AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hi & LVL_SEL_B1_DEF) == '0); // R4

  AST_LEVELS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lv_lo == $past(hi_in))); // R3

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_lo & $past(hi_in & ~lv_lo)) == $past(hi_in & ~lv_lo))); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> $stable(bus_rdata)); // R9

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && addr_bad) |=> (bus_rdata == '0)); // R7
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hi_in    (irq_in[63:32]),
  .lv_lo    (lv_lo),
  .ev_lo    (ev_lo),
  .ev_hi    (ev_hi),
  .pend_any (pend_any),
  .cpu_irq  (cpu_irq),
  .bus_valid(bus_valid),
  .bus_we   (bus_we),
  .addr_bad (addr_bad),
  .bus_rdata(bus_rdata)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_sw;
  logic        irq_o, irq_sw;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  typedef struct {
    bit          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .cpu_irq(irq_o));

  irq_aggregator #(.SWAP_EN(1'b1)) uut_sw (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_sw), .cpu_irq(irq_sw));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, bit sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  // monitor: pops the expected item for each read one edge after the request
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && bus_valid && !bus_we) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          check("scoreboard underflow", 32'h1, 32'h0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(it.tag, it.sel ? rdata_sw : rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 cpu_irq", {31'b0, irq_o}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    bus_read(12'h010, 0, 32'h0, "R1 ev0");
    bus_read(12'h014, 0, 32'h0, "R1 mask0");
    bus_read(12'h01C, 0, 32'h0, "R1 lvl0");
    bus_read(12'h020, 0, 32'h0, "R1 ev1");
    bus_read(12'h024, 0, 32'h0, "R1 mask1");
    bus_read(12'h02C, 0, 32'h0, "R1 lvl1");

    // R2 / R3 / R4 mapping, levels, edge latch
    irq_in[5] = 1'b1; irq_in[40] = 1'b1;
    tick(2);
    bus_read(12'h02C, 0, 32'h0000_0020, "R2 line5 bank1");
    bus_read(12'h01C, 0, 32'h0000_0100, "R2 line40 bank0");
    bus_read(12'h020, 0, 32'h0000_0020, "R4 ev1 latched");
    bus_read(12'h010, 0, 32'h0000_0100, "R4 ev0 latched");
    check("R6 masked off", {31'b0, irq_o}, 32'h0);
    irq_in = '0;
    tick(1);
    bus_read(12'h01C, 0, 32'h0, "R3 lvl0 falls");
    bus_read(12'h010, 0, 32'h0000_0100, "R4 ev0 held");

    // R6 latency on mask and acknowledge
    bus_write(12'h014, 32'h0000_0100);
    check("R6 one-cycle latency", {31'b0, irq_o}, 32'h0);
    tick(1);
    check("R6 raised", {31'b0, irq_o}, 32'h1);
    bus_write(12'h018, 32'h0000_0100);
    check("R6 still up", {31'b0, irq_o}, 32'h1);
    tick(1);
    check("R5 ack drops irq", {31'b0, irq_o}, 32'h0);
    bus_read(12'h010, 0, 32'h0, "R5 ev0 cleared");

    // R4 / R5 level-sensitive bit 20 in bank 1
    irq_in[20] = 1'b1;
    bus_write(12'h024, 32'h0010_0000);
    tick(1);
    check("R6 level pending", {31'b0, irq_o}, 32'h1);
    bus_read(12'h020, 0, 32'h0000_0020, "R4 level no event");
    bus_write(12'h028, 32'hFFFF_FFFF);
    tick(1);
    bus_read(12'h020, 0, 32'h0, "R5 ack all");
    check("R5 level survives ack", {31'b0, irq_o}, 32'h1);
    irq_in[20] = 1'b0;
    tick(2);
    check("R6 level released", {31'b0, irq_o}, 32'h0);

    // R5 edge vs acknowledge in the same cycle
    irq_in[33] = 1'b1;
    bus_write(12'h018, 32'h0000_0002);
    bus_read(12'h010, 0, 32'h0000_0002, "R5 set beats ack");
    bus_write(12'h018, 32'h0000_0002);
    tick(1);
    bus_read(12'h010, 0, 32'h0, "R4 no re-set while high");

    // R7 / R8 decode
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_write(12'h034, 32'hFFFF_FFFF);
    bus_write(12'hF14, 32'hFFFF_FFFF);
    bus_write(12'h016, 32'hFFFF_FFFF);
    bus_write(12'h01C, 32'hFFFF_FFFF);
    bus_write(12'h010, 32'hFFFF_FFFF);
    bus_read(12'h014, 0, 32'h0000_0100, "R7 mask0 untouched");
    bus_read(12'h024, 0, 32'h0010_0000, "R7 mask1 untouched");
    bus_read(12'h010, 0, 32'h0, "R8 events not writable");
    bus_read(12'h018, 0, 32'h0, "R8 ack reads zero");
    bus_read(12'h015, 0, 32'h0, "R8 odd offset zero");
    bus_read(12'h034, 0, 32'h0, "R7 index2 zero");
    bus_read(12'h00C, 0, 32'h0, "R7 below range zero");
    bus_read(12'hF1C, 0, 32'h0, "R7 high addr zero");
    bus_read(12'h01C, 0, 32'h0000_0002, "R8 levels not writable");
    tick(3);
    check("R9 rdata held", rdata, 32'h0000_0002);

    // R10 byte swap variant
    do_reset();
    irq_in[32] = 1'b1;
    tick(2);
    bus_read(12'h01C, 0, 32'h0000_0001, "R10 plain levels");
    bus_read(12'h01C, 1, 32'h0100_0000, "R10 swapped levels");
    bus_write(12'h014, 32'h0000_00FF);
    tick(1);
    check("R10 plain irq", {31'b0, irq_o}, 32'h1);
    check("R10 swapped mask high bytes", {31'b0, irq_sw}, 32'h0);
    bus_read(12'h014, 1, 32'h0000_00FF, "R10 swapped mask readback");
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule